// File: doc/BRIEF.md
# Byte-wide SPI controller with mode-fault detection

This block is a serial peripheral port that a processor drives through three byte registers on a simple strobe bus: a control byte, a status byte and a data byte. In master mode it shifts one byte out and one byte in. It generates the serial clock from the core clock at one of six divide ratios, picked by a 3-bit rate code. In slave mode it follows a serial clock and a select line supplied from outside. Clock polarity and clock phase can be chosen in either mode.

When the eighth bit has been captured, the block sets a completion flag. If the select line is pulled low while the block is a master, it treats this as a mode fault. It records the fault, aborts any transfer in progress, and drops both the enable bit and the master bit so it releases the pins. An interrupt request is raised while interrupts are enabled and either flag is set. Pin multiplexing is reduced to two enable outputs: one for the port as a whole and one for driving the serial clock.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset the control byte and status byte read 0, and `pin_en`, `sck_drive`, `irq` and `sck_out` are all 0.
- R2: Address 0 is the control byte, address 1 the status byte and address 2 the data byte. A read returns its value on `bus_rdata` in the cycle after the access. Control bits from 7 down to 0 are: interrupt enable, port enable, rate bit 2, master select, polarity, phase, rate bit 1, rate bit 0. The control byte reads back exactly as written.
- R3: In master mode the serial clock period, in core cycles, is set by the rate code {bit2,bit1,bit0}: 100 gives 4, 000 gives 8, 001 gives 16, 110 gives 32, 010 gives 64 and 011 gives 128. The unused codes 101 and 111 give 128.
- R4: When no master transfer is running, `sck_out` equals the polarity bit: 0 idles low and 1 idles high.
- R5: A master transfer starts when the data byte is written while the port is enabled and set as master. It sends the byte MSB first on `sdo`, samples `sdi` into the data byte, and then sets status bit 7.
- R6: With phase 0, each bit is captured on the odd-numbered serial clock transitions (1st, 3rd, ...). With phase 1, each bit is captured on the even-numbered transitions (2nd, 4th, ...).
- R7: In slave mode with `ss_n` low, the block follows `sck_in` under the same polarity and phase rules. It receives a byte from `sdi`, sends the preloaded data byte MSB first on `sdo`, and sets status bit 7 after 16 transitions.
- R8: The rate bits have no effect on a slave transfer.
- R9: Status bit 7 clears only on a data-byte access that comes after a status read in which the bit was seen set. A data-byte access without that earlier status read leaves it set.
- R10: If `ss_n` is low while the master bit is 1, the port enable and master bits are cleared and status bit 4 is set. Status bit 4 clears only on a control write that comes after a status read in which it was seen set.
- R11: `irq` is 1 while the interrupt enable bit is 1 and either status bit 7 or status bit 4 is 1. It follows that condition with one cycle of delay and is 0 otherwise.
- R12: `pin_en` follows the port enable bit, and `sck_drive` is 1 only when both the port enable bit and the master bit are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| pin_en | output | 1 | Port owns the serial pins |
| sck_drive | output | 1 | Block drives the serial clock pin |
| sck_out | output | 1 | Serial clock in master mode |
| sck_in | input | 1 | Serial clock in slave mode |
| ss_n | input | 1 | Slave select, active low |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
The assertions assume three things. The bus performs at most one access per strobe cycle. `ss_n` stays high for as long as master mode is meant to keep running. In slave mode each `sck_in` level lasts several core cycles longer than the two-flop synchronizer delay. The bench keeps to all three: it issues single-cycle accesses from one driver task, holds `ss_n` high except during slave transfers and the fault test, and toggles `sck_in` only every eight cycles.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int DIV_CW    = 6;
  localparam int SYNC_LEN  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  // control byte bit positions
  localparam int C_IE   = 7;
  localparam int C_EN   = 6;
  localparam int C_R2   = 5;
  localparam int C_MS   = 4;
  localparam int C_CPOL = 3;
  localparam int C_CPHA = 2;
  localparam int C_R1   = 1;
  localparam int C_R0   = 0;

  // status byte bit positions
  localparam int S_DONE  = 7;
  localparam int S_FAULT = 4;

  // half-period minus one, in core cycles, for each rate code
  function automatic logic [DIV_CW-1:0] half_lim(input logic [2:0] code);
    case (code)
      3'b100:  return DIV_CW'(1);
      3'b000:  return DIV_CW'(3);
      3'b001:  return DIV_CW'(7);
      3'b110:  return DIV_CW'(15);
      3'b010:  return DIV_CW'(31);
      default: return DIV_CW'(63);
    endcase
  endfunction
endpackage

// File: rtl/spi_mf_baud.sv
module spi_mf_baud #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] lim,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/spi_mf_shift.sv
module spi_mf_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         edge_p,
  input  logic         cpha,
  input  logic         sdi,
  output logic         sdo,
  output logic [W-1:0] rx_byte,
  output logic         mid,
  output logic         final_edge
);
  localparam int EW = $clog2(2 * W);
  localparam logic [EW-1:0] LAST = EW'(2 * W - 1);

  logic [EW-1:0] cnt;
  logic [W-1:0]  tx;
  logic [W-1:0]  rx;
  logic          capture;
  logic          hold_first;

  assign capture    = (cnt[0] == cpha);
  assign hold_first = cpha && (cnt == '0);
  assign final_edge = edge_p && (cnt == LAST) && !clr;
  assign sdo        = tx[W-1];
  assign rx_byte    = rx;
  assign mid        = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tx  <= '0;
      rx  <= '0;
    end else begin
      if (load) tx <= load_val;
      if (clr) begin
        cnt <= '0;
      end else if (edge_p) begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (capture)         rx <= {rx[W-2:0], sdi};
        else if (!hold_first) tx <= {tx[W-2:0], 1'b0};
      end
    end
  end

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!edge_p && !clr) |=> $stable(cnt));
  // R5
  final_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    final_edge |=> (cnt == '0));
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
  import spi_mf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              pin_en,
  output logic              sck_drive,
  output logic              sck_out,
  input  logic              sck_in,
  input  logic              ss_n,
  output logic              sdo,
  input  logic              sdi
);
  logic [DATA_W-1:0] ctrl_q;
  logic done_q, fault_q, done_arm, fault_arm;
  logic busy_q, phase_q, irq_q;
  logic [DATA_W-1:0] rdata_q;

  // input synchronizers
  logic [SYNC_LEN-1:0] ss_sync, sdi_sync;
  logic [SYNC_LEN:0]   sck_sync;
  logic ss_s, sdi_s, s_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_sync  <= '1;
      sdi_sync <= '0;
      sck_sync <= '0;
    end else begin
      ss_sync  <= {ss_sync[SYNC_LEN-2:0], ss_n};
      sdi_sync <= {sdi_sync[SYNC_LEN-2:0], sdi};
      sck_sync <= {sck_sync[SYNC_LEN-1:0], sck_in};
    end
  end
  assign ss_s   = ss_sync[SYNC_LEN-1];
  assign sdi_s  = sdi_sync[SYNC_LEN-1];
  assign s_edge = sck_sync[SYNC_LEN] ^ sck_sync[SYNC_LEN-1];

  // decoded control
  logic enabled, is_master, cpha, cpol, int_en;
  logic [2:0] rate_code;
  assign enabled   = ctrl_q[C_EN];
  assign is_master = ctrl_q[C_MS];
  assign cpha      = ctrl_q[C_CPHA];
  assign cpol      = ctrl_q[C_CPOL];
  assign int_en    = ctrl_q[C_IE];
  assign rate_code = {ctrl_q[C_R2], ctrl_q[C_R1], ctrl_q[C_R0]};

  // bus decode
  logic wr_ctrl, rd_stat, acc_data, wr_data;
  assign wr_ctrl  = bus_en && bus_we && (bus_addr == A_CTRL);
  assign rd_stat  = bus_en && !bus_we && (bus_addr == A_STAT);
  assign acc_data = bus_en && (bus_addr == A_DATA);
  assign wr_data  = acc_data && bus_we;

  // engine control
  logic fault_evt, start, slave_sel, edge_p, eng_clr, eng_load;
  logic tick, mid, final_edge, eng_sdi;
  logic [DATA_W-1:0] rx_byte;

  assign fault_evt = is_master && !ss_s;
  assign start     = wr_data && enabled && is_master && !busy_q && !fault_evt;
  assign slave_sel = enabled && !is_master && !ss_s;
  assign edge_p    = is_master ? (tick && busy_q) : (slave_sel && s_edge);
  assign eng_clr   = fault_evt || !enabled || (!is_master && ss_s);
  assign eng_load  = wr_data && !busy_q && !mid && !fault_evt;
  assign eng_sdi   = is_master ? sdi : sdi_s;

  spi_mf_baud #(.CW(DIV_CW)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_q),
    .lim  (half_lim(rate_code)),
    .tick (tick)
  );

  spi_mf_shift #(.W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .clr        (eng_clr),
    .load       (eng_load),
    .load_val   (bus_wdata),
    .edge_p     (edge_p),
    .cpha       (cpha),
    .sdi        (eng_sdi),
    .sdo        (sdo),
    .rx_byte    (rx_byte),
    .mid        (mid),
    .final_edge (final_edge)
  );

  // master clock state
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      if (fault_evt || !enabled || final_edge) busy_q <= 1'b0;
      else if (start)                          busy_q <= 1'b1;
      if (!busy_q || fault_evt || !enabled)    phase_q <= 1'b0;
      else if (edge_p)                         phase_q <= !phase_q;
    end
  end
  assign sck_out = cpol ^ phase_q;

  // registers and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      done_arm  <= 1'b0;
      fault_arm <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (fault_evt) begin
        ctrl_q[C_EN] <= 1'b0;
        ctrl_q[C_MS] <= 1'b0;
      end

      if (final_edge)                 done_q <= 1'b1;
      else if (acc_data && done_arm)  done_q <= 1'b0;
      if (rd_stat)                    done_arm <= done_q;
      else if (acc_data)              done_arm <= 1'b0;

      if (fault_evt)                  fault_q <= 1'b1;
      else if (wr_ctrl && fault_arm)  fault_q <= 1'b0;
      if (rd_stat)                    fault_arm <= fault_q;
      else if (wr_ctrl)               fault_arm <= 1'b0;

      irq_q <= int_en && (done_q || fault_q);
    end
  end

  logic [DATA_W-1:0] stat_v;
  always_comb begin
    stat_v          = '0;
    stat_v[S_DONE]  = done_q;
    stat_v[S_FAULT] = fault_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_en && !bus_we) begin
      case (bus_addr)
        A_CTRL:  rdata_q <= ctrl_q;
        A_STAT:  rdata_q <= stat_v;
        A_DATA:  rdata_q <= rx_byte;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
  assign pin_en    = enabled;
  assign sck_drive = enabled && is_master;

  // R10
  fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> (!ctrl_q[C_EN] && !ctrl_q[C_MS] && fault_q));
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> !irq_q);
  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (sck_out == cpol));
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !done_arm) |=> done_q);
endmodule

// File: tb/spi_mf_ctrl_test.sv
module spi_mf_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic irq, pin_en, sck_drive, sck_out, sdo, sdi;
  logic sck_drv = 1'b0, ss_drv = 1'b1, sdi_drv = 1'b0;
  logic slv_mode = 1'b0, lb_inv = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sdi = slv_mode ? sdi_drv : (sdo ^ lb_inv);

  spi_mf_ctrl uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .pin_en(pin_en), .sck_drive(sck_drive), .sck_out(sck_out),
    .sck_in(sck_drv), .ss_n(ss_drv), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] mk(input bit ie, input bit en, input logic [2:0] code,
                                    input bit ms, input bit cpol, input bit cpha);
    return {ie, en, code[2], ms, cpol, cpha, code[1], code[0]};
  endfunction

  function automatic int exp_div(input logic [2:0] code);
    case (code)
      3'b100: return 4;
      3'b000: return 8;
      3'b001: return 16;
      3'b110: return 32;
      3'b010: return 64;
      default: return 128;
    endcase
  endfunction

  // scoreboard: expected {period, byte} per master transfer
  int exp_q[$];
  bit mon_on = 0;
  bit cur_cpha = 0;
  logic mon_prev = 1'b0;
  int mcnt = 0, t0 = 0;
  logic [7:0] mbits = 8'd0;

  always @(negedge clk) begin
    if (!mon_on) begin
      mcnt = 0;
      mon_prev = sck_out;
    end else if (sck_out !== mon_prev) begin
      mon_prev = sck_out;
      if (mcnt == 0) t0 = cyc;
      if (mcnt == 2 && exp_q.size() > 0)
        chk("R3 sck period", cyc - t0, exp_q[0] >> 8);
      if ((mcnt % 2) == int'(cur_cpha)) mbits = {mbits[6:0], sdo};
      mcnt++;
      if (mcnt == 16) begin
        if (exp_q.size() > 0) begin
          chk("R6 bits seen at capture edges", mbits, exp_q[0] & 8'hFF);
          void'(exp_q.pop_front());
        end else begin
          chk("R5 unexpected master transfer", 1, 0);
        end
        mcnt = 0;
      end
    end
  end

  task automatic wait_done(input string tag);
    logic [7:0] s;
    bit seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      bus_rd(2'd1, s);
      if (s[7]) seen = 1;
    end
    chk(tag, int'(seen), 1);
  endtask

  task automatic master_xfer(input logic [7:0] cv, input logic [7:0] txb,
                             input bit inv, input bit poll);
    logic [7:0] d;
    mon_on = 0;
    bus_wr(2'd0, cv);
    cur_cpha = cv[2];
    lb_inv = inv;
    @(negedge clk);
    mon_on = 1;
    exp_q.push_back((exp_div({cv[5], cv[1], cv[0]}) << 8) | int'(txb));
    bus_wr(2'd2, txb);
    if (poll) begin
      wait_done("R5 done flag");
      bus_rd(2'd2, d);
      chk("R5 received byte", d, txb ^ (inv ? 8'hFF : 8'h00));
      chk("R4 sck idle after transfer", sck_out, cv[3]);
    end else begin
      repeat (400) @(negedge clk);
    end
    mon_on = 0;
  endtask

  task automatic slave_xfer(input logic [2:0] code, input bit cpol, input bit cpha,
                            input logic [7:0] txb, input logic [7:0] rxb, input string tag);
    logic [7:0] got, d;
    slv_mode = 1;
    sck_drv = cpol;
    bus_wr(2'd0, mk(0, 1, code, 0, cpol, cpha));
    bus_wr(2'd2, txb);
    ss_drv = 1'b0;
    repeat (8) @(negedge clk);
    got = 8'd0;
    for (int i = 0; i < 16; i++) begin
      bit cap;
      cap = ((i % 2) == int'(cpha));
      if (cap) sdi_drv = rxb[7 - i / 2];
      repeat (8) @(negedge clk);
      if (cap) got[7 - i / 2] = sdo;
      sck_drv = ~sck_drv;
    end
    repeat (8) @(negedge clk);
    ss_drv = 1'b1;
    repeat (4) @(negedge clk);
    wait_done({tag, " done flag"});
    bus_rd(2'd2, d);
    chk({tag, " received byte"}, d, rxb);
    chk({tag, " sent byte"}, got, txb);
    slv_mode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1
    chk("R1 pin_en", pin_en, 0);
    chk("R1 sck_drive", sck_drive, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sck_out", sck_out, 0);
    bus_rd(2'd0, d); chk("R1 ctrl", d, 0);
    bus_rd(2'd1, d); chk("R1 status", d, 0);

    // R2 / R12
    bus_wr(2'd0, 8'hA5);
    bus_rd(2'd0, d); chk("R2 ctrl readback", d, 8'hA5);
    chk("R12 pin_en off", pin_en, 0);
    bus_wr(2'd0, mk(0, 1, 3'b000, 0, 1, 0));
    @(negedge clk);
    chk("R12 pin_en slave", pin_en, 1);
    chk("R12 sck_drive slave", sck_drive, 0);
    bus_wr(2'd0, mk(0, 1, 3'b000, 1, 1, 0));
    @(negedge clk);
    chk("R12 sck_drive master", sck_drive, 1);
    chk("R4 idle high", sck_out, 1);

    // R3: every rate code
    for (int c = 0; c < 8; c++)
      master_xfer(mk(0, 1, 3'(c), 1, 0, 0), 8'(c * 37 + 5), 0, 1);

    // R4 / R6: polarity and phase combinations, with plain and inverted loopback
    for (int m = 0; m < 4; m++)
      master_xfer(mk(0, 1, 3'b100, 1, m[1], m[0]), 8'(8'h96 ^ (m * 8'h11)), m[0], 1);

    chk("R5 scoreboard drained", exp_q.size(), 0);

    // R9 / R11: flag clearing order and interrupt
    master_xfer(mk(1, 1, 3'b100, 1, 0, 1), 8'h3C, 0, 0);
    chk("R11 irq on done", irq, 1);
    bus_rd(2'd2, d);
    bus_rd(2'd1, d); chk("R9 done kept without prior status read", d[7], 1);
    bus_rd(2'd2, d);
    bus_rd(2'd1, d); chk("R9 done cleared", d[7], 0);
    repeat (2) @(negedge clk);
    chk("R11 irq off after clear", irq, 0);
    master_xfer(mk(1, 1, 3'b100, 1, 0, 0), 8'h5A, 0, 0);
    bus_wr(2'd0, mk(0, 1, 3'b100, 1, 0, 0));
    repeat (2) @(negedge clk);
    chk("R11 irq masked", irq, 0);
    bus_rd(2'd1, d); bus_rd(2'd2, d);

    // R10: mode fault
    bus_wr(2'd0, mk(1, 1, 3'b000, 1, 0, 0));
    ss_drv = 1'b0;
    repeat (6) @(negedge clk);
    bus_rd(2'd0, d); chk("R10 en and master cleared", d, mk(1, 0, 3'b000, 0, 0, 0));
    bus_rd(2'd1, d); chk("R10 fault flag", d[4], 1);
    chk("R10 pin_en released", pin_en, 0);
    chk("R11 irq on fault", irq, 1);
    ss_drv = 1'b1;
    repeat (4) @(negedge clk);
    bus_wr(2'd0, 8'h80);
    bus_rd(2'd1, d); chk("R10 fault cleared by status read then ctrl write", d[4], 0);
    bus_wr(2'd0, 8'h80);
    bus_rd(2'd1, d); chk("R10 fault stays clear", d[4], 0);
    bus_wr(2'd0, mk(1, 1, 3'b000, 1, 0, 0));
    ss_drv = 1'b0;
    repeat (6) @(negedge clk);
    ss_drv = 1'b1;
    repeat (4) @(negedge clk);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd1, d); chk("R10 fault kept without prior status read", d[4], 1);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd1, d); chk("R10 fault cleared", d[4], 0);

    // R7 / R8: slave transfers
    slave_xfer(3'b000, 0, 0, 8'hC3, 8'h5A, "R7 mode0");
    slave_xfer(3'b000, 0, 1, 8'h81, 8'h7E, "R7 mode1");
    slave_xfer(3'b000, 1, 0, 8'h2D, 8'hB4, "R7 mode2");
    slave_xfer(3'b000, 1, 1, 8'hF0, 8'h0F, "R7 mode3");
    slave_xfer(3'b100, 0, 1, 8'h81, 8'h7E, "R8 fast code");
    slave_xfer(3'b011, 0, 1, 8'h81, 8'h7E, "R8 slow code");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule